// File: doc/BRIEF.md
# Indexed Predicted Store-Load Forwarding

This block is the forwarding slice of a load/store unit. Stores sit in a circular store queue, each tagged with a sequence number. A load never compares its address against every queued store. Instead, a direct-mapped table indexed by the load's PC holds a store distance. The unit subtracts this distance from the store-queue tail that the load captured at dispatch, which names exactly one candidate store. It then reads that single entry by index and forwards its data only if the entry is live, is that very store, holds both address and data, and has an address equal to the load's. In every other case the load takes the data supplied by the cache side.

Speculation is verified later. At commit time the pipeline presents each load again, in program order, and the unit reads the cache through the one data port it shares with store commit. A committing store always wins that port, and the load waits. When the load gets the port, the unit compares the fresh value with the value the load first returned. If they differ, it raises a flush for the load and everything younger. On a flush it also retrains the table entry. The correct distance comes from a small direct-mapped log of the most recent committed store to each address. If no store that was in flight fed the load, the entry is invalidated.

Top module: `idx_fwd_lsu`

## Requirements
- R1: After reset the store queue is empty (`sq_tail` = 0, `sq_full` = 0), no load result is valid, the data port is idle and every predictor entry is invalid.
- R2: Each allocation advances `sq_tail` by one. With SQ_DEPTH stores held, `sq_full` is 1 and a further allocation leaves `sq_tail` unchanged.
- R3: A load whose predicted store (sequence `ld_snap - distance`) is live, has address and data ready, and has an address equal to `ld_addr` returns `ld_res_fwd` = 1 with that store's data one cycle after `ld_vld`.
- R4: When the predicted store's address differs from `ld_addr`, the result is `ld_cache_data` with `ld_res_fwd` = 0.
- R5: When the predicted store is live but its data is not yet written, the result is `ld_cache_data` with `ld_res_fwd` = 0.
- R6: When the predicted sequence names a store that has already committed, the result is `ld_cache_data` with `ld_res_fwd` = 0.
- R7: A load whose PC maps to an invalid predictor entry returns `ld_cache_data` with `ld_res_fwd` = 0.
- R8: While `st_commit_req` is high and the queue is not empty, the port writes the head store (`dc_we` = 1, head address and data), `st_commit_ack` is 1 and `rx_done` stays 0 in the same cycle.
- R9: A waiting re-execution gets the port (`rx_done` = 1, `dc_we` = 0, `dc_addr` = `rx_addr`) in any cycle without a store commit. `rx_flush` is 1 exactly when `dc_rdata` differs from `rx_orig_data`.
- R10: On a flush where the most recent committed store to `rx_addr` lies 1 to SQ_DEPTH sequence numbers below `rx_snap`, the predictor entry for `rx_pc` learns that gap as its distance, so a later load from that PC forwards.
- R11: On a flush with no such store, the predictor entry for `rx_pc` becomes invalid, and a later load from that PC does not forward.
- R12: A granted commit frees the head entry, so a full queue stops reporting `sq_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_alloc_vld | input | 1 | Allocate the next store-queue entry at the tail |
| sq_tail | output | SEQ_W | Sequence number the next allocated store receives |
| sq_full | output | 1 | Queue holds SQ_DEPTH stores |
| st_agen_vld | input | 1 | Store address write |
| st_agen_idx | input | SQ_IDX_W | Entry receiving the address |
| st_agen_addr | input | AW | Store address |
| st_dgen_vld | input | 1 | Store data write |
| st_dgen_idx | input | SQ_IDX_W | Entry receiving the data |
| st_dgen_data | input | DW | Store data |
| st_commit_req | input | 1 | Head store retires and wants the cache port |
| st_commit_ack | output | 1 | Head store written to the cache this cycle |
| ld_vld | input | 1 | Load executes this cycle |
| ld_pc | input | PC_W | Load PC |
| ld_addr | input | AW | Load address |
| ld_snap | input | SEQ_W | Tail sequence captured when the load dispatched |
| ld_cache_data | input | DW | Data from the cache side for this load |
| ld_res_vld | output | 1 | Load result valid |
| ld_res_fwd | output | 1 | Result came from a store |
| ld_res_data | output | DW | Load result data |
| rx_vld | input | 1 | Oldest load awaits re-execution before commit |
| rx_pc | input | PC_W | PC of that load |
| rx_addr | input | AW | Address of that load |
| rx_snap | input | SEQ_W | Tail snapshot of that load |
| rx_orig_data | input | DW | Value the load returned at execution |
| rx_done | output | 1 | Re-execution used the port this cycle |
| rx_flush | output | 1 | Re-executed value differs; flush load and younger |
| dc_vld | output | 1 | Cache port active |
| dc_we | output | 1 | Cache port write |
| dc_addr | output | AW | Cache port address |
| dc_wdata | output | DW | Cache port write data |
| dc_rdata | input | DW | Cache port read data, same cycle |

## Verification
A predictor entry holding a stale or wrong distance does not hang the block. It shows up one cycle after a load as `ld_res_fwd` = 0 with cache data where the bench expects store data, or the reverse, and at re-execution as an unexpected `rx_flush`. A corrupted training write stays hidden until the next load from the same PC, so the bench always follows a flush with such a load. Queue pointer errors appear on `sq_tail` and `sq_full` in the cycle after the allocation or commit. Port arbitration errors appear as `rx_done` together with `dc_we` in the same cycle.

// File: rtl/idxfwd_pkg.sv
package idxfwd_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE   = 2'd0,
    PORT_STORE  = 2'd1,
    PORT_RELOAD = 2'd2
  } port_own_e;
endpackage

// File: rtl/fwd_dist_table.sv
module fwd_dist_table #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int DIST_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   rd_pc,
  output logic              rd_hit,
  output logic [DIST_W-1:0] rd_dist,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_valid,
  input  logic [DIST_W-1:0] wr_dist
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [DIST_W-1:0]  dist_q [ENTRIES];
  logic [DIST_W-1:0]  dist_d [ENTRIES];
  logic [IDX_W-1:0]   rd_idx, wr_idx;

  assign rd_idx  = rd_pc[PC_LSB +: IDX_W];
  assign wr_idx  = wr_pc[PC_LSB +: IDX_W];
  assign rd_hit  = vld_q[rd_idx];
  assign rd_dist = dist_q[rd_idx];

  always_comb begin
    vld_d  = vld_q;
    dist_d = dist_q;
    if (wr_en) begin
      vld_d[wr_idx]  = wr_valid;
      dist_d[wr_idx] = wr_dist;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    dist_q <= dist_d;
  end

  AST_TRAIN_DIST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |-> (wr_dist != '0)); // R10
endmodule

// File: rtl/sq_ring.sv
module sq_ring #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 8,
  parameter int AW    = 32,
  parameter int DW    = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_vld,
  output logic [SEQ_W-1:0]         tail_seq,
  output logic                     full,
  output logic                     empty,
  input  logic                     agen_vld,
  input  logic [$clog2(DEPTH)-1:0] agen_idx,
  input  logic [AW-1:0]            agen_addr,
  input  logic                     dgen_vld,
  input  logic [$clog2(DEPTH)-1:0] dgen_idx,
  input  logic [DW-1:0]            dgen_data,
  input  logic                     commit_en,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [SEQ_W-1:0]         head_seq,
  output logic                     head_ready,
  input  logic [SEQ_W-1:0]         rd_seq,
  output logic                     rd_hit,
  output logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SEQ_W-1:0] head_q, head_d, tail_q, tail_d, count;
  logic [DEPTH-1:0] vld_q, vld_d, ardy_q, ardy_d, drdy_q, drdy_d;
  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [SEQ_W-1:0] seq_d  [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];
  logic [AW-1:0]    addr_d [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DW-1:0]    data_d [DEPTH];
  logic [IDX_W-1:0] head_idx, tail_idx, rd_idx;
  logic             alloc_ok, commit_ok;

  assign count     = tail_q - head_q;
  assign full      = (count == SEQ_W'(DEPTH));
  assign empty     = (count == '0);
  assign alloc_ok  = alloc_vld && !full;
  assign commit_ok = commit_en && !empty;
  assign head_idx  = head_q[IDX_W-1:0];
  assign tail_idx  = tail_q[IDX_W-1:0];
  assign tail_seq  = tail_q;
  assign head_seq  = head_q;
  assign head_addr = addr_q[head_idx];
  assign head_data = data_q[head_idx];
  assign head_ready = vld_q[head_idx] && ardy_q[head_idx] && drdy_q[head_idx];

  // single indexed read at the predicted position
  assign rd_idx  = rd_seq[IDX_W-1:0];
  assign rd_hit  = vld_q[rd_idx] && (seq_q[rd_idx] == rd_seq) &&
                   ardy_q[rd_idx] && drdy_q[rd_idx];
  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    vld_d  = vld_q;
    ardy_d = ardy_q;
    drdy_d = drdy_q;
    seq_d  = seq_q;
    addr_d = addr_q;
    data_d = data_q;
    if (agen_vld) begin
      ardy_d[agen_idx] = 1'b1;
      addr_d[agen_idx] = agen_addr;
    end
    if (dgen_vld) begin
      drdy_d[dgen_idx] = 1'b1;
      data_d[dgen_idx] = dgen_data;
    end
    if (commit_ok) begin
      vld_d[head_idx] = 1'b0;
      head_d          = head_q + SEQ_W'(1);
    end
    if (alloc_ok) begin
      vld_d[tail_idx]  = 1'b1;
      ardy_d[tail_idx] = 1'b0;
      drdy_d[tail_idx] = 1'b0;
      seq_d[tail_idx]  = tail_q;
      tail_d           = tail_q + SEQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      vld_q  <= '0;
      ardy_q <= '0;
      drdy_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      vld_q  <= vld_d;
      ardy_q <= ardy_d;
      drdy_q <= drdy_d;
    end
  end

  always_ff @(posedge clk) begin
    seq_q  <= seq_d;
    addr_q <= addr_d;
    data_q <= data_d;
  end

  AST_OCCUPANCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= SEQ_W'(DEPTH)); // R2
  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && full && !commit_en) |=> $stable(tail_q)); // R2
  AST_TAIL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && !full) |=> (tail_q == $past(tail_q) + SEQ_W'(1))); // R2
  AST_COMMIT_HEAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> head_ready); // R12
endmodule

// File: rtl/commit_log.sv
module commit_log #(
  parameter int ENTRIES  = 16,
  parameter int SEQ_W    = 8,
  parameter int AW       = 32,
  parameter int ADDR_LSB = 2,
  parameter int WINDOW   = 16,
  parameter int DIST_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [AW-1:0]     lk_addr,
  input  logic [SEQ_W-1:0]  lk_snap,
  output logic              lk_hit,
  output logic [DIST_W-1:0] lk_dist
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [AW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tag_d [ENTRIES];
  logic [SEQ_W-1:0]   seq_q [ENTRIES];
  logic [SEQ_W-1:0]   seq_d [ENTRIES];
  logic [IDX_W-1:0]   wr_idx, lk_idx;
  logic [SEQ_W-1:0]   gap;

  assign wr_idx  = wr_addr[ADDR_LSB +: IDX_W];
  assign lk_idx  = lk_addr[ADDR_LSB +: IDX_W];
  assign gap     = lk_snap - seq_q[lk_idx];
  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_addr) &&
                   (gap != '0) && (gap <= SEQ_W'(WINDOW));
  assign lk_dist = gap[DIST_W-1:0];

  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    seq_d = seq_q;
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
      tag_d[wr_idx] = wr_addr;
      seq_d[wr_idx] = wr_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    tag_q <= tag_d;
    seq_q <= seq_d;
  end

  AST_LOG_DIST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_dist != '0)); // R10
endmodule

// File: rtl/idx_fwd_lsu.sv
module idx_fwd_lsu
  import idxfwd_pkg::*;
#(
  parameter int SQ_DEPTH     = 16,
  parameter int SEQ_W        = 8,
  parameter int PRED_ENTRIES = 64,
  parameter int LOG_ENTRIES  = 16,
  parameter int PC_W         = 32,
  parameter int AW           = 32,
  parameter int DW           = 64,
  parameter int SQ_IDX_W     = $clog2(SQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_alloc_vld,
  output logic [SEQ_W-1:0]    sq_tail,
  output logic                sq_full,
  input  logic                st_agen_vld,
  input  logic [SQ_IDX_W-1:0] st_agen_idx,
  input  logic [AW-1:0]       st_agen_addr,
  input  logic                st_dgen_vld,
  input  logic [SQ_IDX_W-1:0] st_dgen_idx,
  input  logic [DW-1:0]       st_dgen_data,
  input  logic                st_commit_req,
  output logic                st_commit_ack,
  input  logic                ld_vld,
  input  logic [PC_W-1:0]     ld_pc,
  input  logic [AW-1:0]       ld_addr,
  input  logic [SEQ_W-1:0]    ld_snap,
  input  logic [DW-1:0]       ld_cache_data,
  output logic                ld_res_vld,
  output logic                ld_res_fwd,
  output logic [DW-1:0]       ld_res_data,
  input  logic                rx_vld,
  input  logic [PC_W-1:0]     rx_pc,
  input  logic [AW-1:0]       rx_addr,
  input  logic [SEQ_W-1:0]    rx_snap,
  input  logic [DW-1:0]       rx_orig_data,
  output logic                rx_done,
  output logic                rx_flush,
  output logic                dc_vld,
  output logic                dc_we,
  output logic [AW-1:0]       dc_addr,
  output logic [DW-1:0]       dc_wdata,
  input  logic [DW-1:0]       dc_rdata
);
  localparam int DIST_W = SQ_IDX_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic              pred_hit;
  logic [DIST_W-1:0] pred_dist;
  logic [SEQ_W-1:0]  pred_seq;
  logic              sq_hit, sq_empty, head_ready;
  logic [AW-1:0]     sq_rd_addr, head_addr;
  logic [DW-1:0]     sq_rd_data, head_data;
  logic [SEQ_W-1:0]  head_seq;
  logic              log_hit;
  logic [DIST_W-1:0] log_dist;
  port_own_e         port_own;

  fwd_dist_table #(
    .ENTRIES(PRED_ENTRIES), .PC_W(PC_W), .PC_LSB(2), .DIST_W(DIST_W)
  ) pred_i (
    .clk(clk), .rst_n(rst_n_s),
    .rd_pc(ld_pc), .rd_hit(pred_hit), .rd_dist(pred_dist),
    .wr_en(rx_flush), .wr_pc(rx_pc), .wr_valid(log_hit), .wr_dist(log_dist)
  );

  assign pred_seq = ld_snap - SEQ_W'(pred_dist);

  sq_ring #(
    .DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .DW(DW)
  ) sq_i (
    .clk(clk), .rst_n(rst_n_s),
    .alloc_vld(st_alloc_vld), .tail_seq(sq_tail), .full(sq_full), .empty(sq_empty),
    .agen_vld(st_agen_vld), .agen_idx(st_agen_idx), .agen_addr(st_agen_addr),
    .dgen_vld(st_dgen_vld), .dgen_idx(st_dgen_idx), .dgen_data(st_dgen_data),
    .commit_en(st_commit_ack),
    .head_addr(head_addr), .head_data(head_data), .head_seq(head_seq),
    .head_ready(head_ready),
    .rd_seq(pred_seq), .rd_hit(sq_hit), .rd_addr(sq_rd_addr), .rd_data(sq_rd_data)
  );

  commit_log #(
    .ENTRIES(LOG_ENTRIES), .SEQ_W(SEQ_W), .AW(AW), .ADDR_LSB(2),
    .WINDOW(SQ_DEPTH), .DIST_W(DIST_W)
  ) log_i (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(st_commit_ack), .wr_addr(head_addr), .wr_seq(head_seq),
    .lk_addr(rx_addr), .lk_snap(rx_snap), .lk_hit(log_hit), .lk_dist(log_dist)
  );

  // execution-time forwarding decision
  logic          fwd_d;
  logic [DW-1:0] data_d;
  logic          res_vld_q, res_fwd_q;
  logic [DW-1:0] res_data_q;

  assign fwd_d  = ld_vld && pred_hit && sq_hit && (sq_rd_addr == ld_addr);
  assign data_d = fwd_d ? sq_rd_data : ld_cache_data;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_vld_q <= 1'b0;
      res_fwd_q <= 1'b0;
    end else begin
      res_vld_q <= ld_vld;
      res_fwd_q <= fwd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_vld) res_data_q <= data_d;
  end

  assign ld_res_vld  = res_vld_q;
  assign ld_res_fwd  = res_fwd_q;
  assign ld_res_data = res_data_q;

  // shared cache port: store commit first, re-execution otherwise
  always_comb begin
    if (st_commit_req && !sq_empty) port_own = PORT_STORE;
    else if (rx_vld)                port_own = PORT_RELOAD;
    else                            port_own = PORT_IDLE;
  end

  assign st_commit_ack = (port_own == PORT_STORE);
  assign rx_done       = (port_own == PORT_RELOAD);
  assign rx_flush      = rx_done && (dc_rdata != rx_orig_data);
  assign dc_vld        = (port_own != PORT_IDLE);
  assign dc_we         = (port_own == PORT_STORE);
  assign dc_addr       = (port_own == PORT_STORE) ? head_addr : rx_addr;
  assign dc_wdata      = head_data;

  AST_STORE_WINS_PORT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_commit_req && !sq_empty) |-> !rx_done); // R8
  AST_PORT_SINGLE_USER: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(dc_we && rx_done)); // R8
  AST_RELOAD_NOT_STARVED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_vld && !st_commit_req) |-> rx_done); // R9
  AST_FWD_ONLY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n_s)
    ld_res_fwd |-> ld_res_vld); // R3
endmodule

// File: tb/idx_fwd_lsu_tb_top.sv
module idx_fwd_lsu_tb_top;
  localparam int SQ_DEPTH = 8;
  localparam int SEQ_W    = 6;
  localparam int PC_W     = 16;
  localparam int AW       = 16;
  localparam int DW       = 32;
  localparam int IW       = 3;

  localparam logic [AW-1:0] ADDR_A = 16'h0100;
  localparam logic [AW-1:0] ADDR_B = 16'h0204;
  localparam logic [PC_W-1:0] PC0  = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic st_alloc_vld = 0, st_agen_vld = 0, st_dgen_vld = 0, st_commit_req = 0;
  logic [IW-1:0] st_agen_idx = '0, st_dgen_idx = '0;
  logic [AW-1:0] st_agen_addr = '0;
  logic [DW-1:0] st_dgen_data = '0;
  logic ld_vld = 0;
  logic [PC_W-1:0] ld_pc = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [SEQ_W-1:0] ld_snap = '0;
  logic [DW-1:0] ld_cache_data = '0;
  logic rx_vld = 0;
  logic [PC_W-1:0] rx_pc = '0;
  logic [AW-1:0] rx_addr = '0;
  logic [SEQ_W-1:0] rx_snap = '0;
  logic [DW-1:0] rx_orig_data = '0;
  logic [SEQ_W-1:0] sq_tail;
  logic sq_full, st_commit_ack, ld_res_vld, ld_res_fwd, rx_done, rx_flush;
  logic dc_vld, dc_we;
  logic [DW-1:0] ld_res_data, dc_wdata, dc_rdata;
  logic [AW-1:0] dc_addr;

  logic [DW-1:0] mem [16];
  assign dc_rdata = mem[dc_addr[5:2]];
  always @(posedge clk) if (dc_vld && dc_we) mem[dc_addr[5:2]] <= dc_wdata;

  idx_fwd_lsu #(
    .SQ_DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W), .PRED_ENTRIES(16), .LOG_ENTRIES(8),
    .PC_W(PC_W), .AW(AW), .DW(DW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_alloc_vld(st_alloc_vld), .sq_tail(sq_tail), .sq_full(sq_full),
    .st_agen_vld(st_agen_vld), .st_agen_idx(st_agen_idx), .st_agen_addr(st_agen_addr),
    .st_dgen_vld(st_dgen_vld), .st_dgen_idx(st_dgen_idx), .st_dgen_data(st_dgen_data),
    .st_commit_req(st_commit_req), .st_commit_ack(st_commit_ack),
    .ld_vld(ld_vld), .ld_pc(ld_pc), .ld_addr(ld_addr), .ld_snap(ld_snap),
    .ld_cache_data(ld_cache_data),
    .ld_res_vld(ld_res_vld), .ld_res_fwd(ld_res_fwd), .ld_res_data(ld_res_data),
    .rx_vld(rx_vld), .rx_pc(rx_pc), .rx_addr(rx_addr), .rx_snap(rx_snap),
    .rx_orig_data(rx_orig_data), .rx_done(rx_done), .rx_flush(rx_flush),
    .dc_vld(dc_vld), .dc_we(dc_we), .dc_addr(dc_addr), .dc_wdata(dc_wdata),
    .dc_rdata(dc_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic fwd; logic [DW-1:0] data; string req; } exp_t;
  exp_t expq[$];

  always @(negedge clk) begin
    if (rst_n && ld_res_vld) begin
      if (expq.size() == 0) begin
        chk("R3 unexpected load result", 64'(ld_res_vld), 64'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.req, " fwd"}, 64'(ld_res_fwd), 64'(e.fwd));
        chk({e.req, " data"}, 64'(ld_res_data), 64'(e.data));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_alloc();
    st_alloc_vld = 1; tick(); st_alloc_vld = 0;
  endtask

  task automatic do_agen(input logic [IW-1:0] idx, input logic [AW-1:0] a);
    st_agen_vld = 1; st_agen_idx = idx; st_agen_addr = a; tick(); st_agen_vld = 0;
  endtask

  task automatic do_dgen(input logic [IW-1:0] idx, input logic [DW-1:0] d);
    st_dgen_vld = 1; st_dgen_idx = idx; st_dgen_data = d; tick(); st_dgen_vld = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [SEQ_W-1:0] snap,
                         input logic [DW-1:0] cache, input logic efwd,
                         input logic [DW-1:0] edata, input string req);
    exp_t e;
    e.fwd = efwd; e.data = edata; e.req = req;
    expq.push_back(e);
    ld_vld = 1; ld_pc = PC0; ld_addr = a; ld_snap = snap; ld_cache_data = cache;
    tick(); ld_vld = 0;
  endtask

  task automatic do_commit(input logic [AW-1:0] ea, input logic [DW-1:0] ed, input string req);
    st_commit_req = 1; #1;
    chk({req, " ack"}, 64'(st_commit_ack), 64'd1);
    chk({req, " we"}, 64'(dc_we), 64'd1);
    chk({req, " addr"}, 64'(dc_addr), 64'(ea));
    chk({req, " wdata"}, 64'(dc_wdata), 64'(ed));
    tick(); st_commit_req = 0;
  endtask

  task automatic do_reexec(input logic [AW-1:0] a, input logic [SEQ_W-1:0] snap,
                           input logic [DW-1:0] orig, input logic eflush, input string req);
    rx_vld = 1; rx_pc = PC0; rx_addr = a; rx_snap = snap; rx_orig_data = orig; #1;
    chk({req, " done"}, 64'(rx_done), 64'd1);
    chk({req, " we"}, 64'(dc_we), 64'd0);
    chk({req, " flush"}, 64'(rx_flush), 64'(eflush));
    tick(); rx_vld = 0;
  endtask

  task automatic run_all();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    // R1 reset state
    chk("R1 tail", 64'(sq_tail), 64'd0);
    chk("R1 full", 64'(sq_full), 64'd0);
    chk("R1 res_vld", 64'(ld_res_vld), 64'd0);
    chk("R1 dc_vld", 64'(dc_vld), 64'd0);
    do_load(ADDR_A, 6'd0, 32'h11, 1'b0, 32'h11, "R1 R7 no prediction after reset");
    tick();
    // first store, prediction absent
    do_alloc();
    chk("R2 tail after alloc", 64'(sq_tail), 64'd1);
    do_agen(3'd0, ADDR_A);
    do_dgen(3'd0, 32'hAAAA0000);
    do_load(ADDR_A, 6'd1, 32'h22, 1'b0, 32'h22, "R7 invalid entry uses cache");
    tick();
    do_commit(ADDR_A, 32'hAAAA0000, "R8 commit S0");
    do_reexec(ADDR_A, 6'd1, 32'h22, 1'b1, "R9 mismatch flushes");
    // trained distance 1
    do_alloc();
    do_agen(3'd1, ADDR_A);
    do_dgen(3'd1, 32'hBBBB0001);
    do_load(ADDR_A, 6'd2, 32'h33, 1'b1, 32'hBBBB0001, "R3 R10 trained forward");
    tick();
    do_load(ADDR_B, 6'd2, 32'h44, 1'b0, 32'h44, "R4 address mismatch");
    tick();
    do_alloc();
    do_agen(3'd2, ADDR_A);
    do_load(ADDR_A, 6'd3, 32'h55, 1'b0, 32'h55, "R5 data not ready");
    tick();
    do_load(ADDR_A, 6'd1, 32'h66, 1'b0, 32'h66, "R6 predicted store committed");
    tick();
    // R8 priority, then R9 grant without flush
    rx_vld = 1; rx_pc = PC0; rx_addr = ADDR_A; rx_snap = 6'd2; rx_orig_data = 32'hBBBB0001;
    st_commit_req = 1; #1;
    chk("R8 store wins ack", 64'(st_commit_ack), 64'd1);
    chk("R8 reload waits", 64'(rx_done), 64'd0);
    chk("R8 wdata", 64'(dc_wdata), 64'hBBBB0001);
    tick(); st_commit_req = 0; #1;
    chk("R9 reload granted", 64'(rx_done), 64'd1);
    chk("R9 read addr", 64'(dc_addr), 64'(ADDR_A));
    chk("R9 equal no flush", 64'(rx_flush), 64'd0);
    tick(); rx_vld = 0;
    // R11 clear on unmatched flush
    do_reexec(ADDR_B, 6'd3, 32'h77, 1'b1, "R11 flush without feeder");
    do_dgen(3'd2, 32'hCCCC0002);
    do_load(ADDR_A, 6'd3, 32'h88, 1'b0, 32'h88, "R11 cleared entry no forward");
    tick();
    // R2 full, R12 commit frees
    for (int i = 0; i < 7; i++) do_alloc();
    chk("R2 tail at full", 64'(sq_tail), 64'd10);
    chk("R2 full flag", 64'(sq_full), 64'd1);
    do_alloc();
    chk("R2 alloc refused", 64'(sq_tail), 64'd10);
    do_commit(ADDR_A, 32'hCCCC0002, "R12 commit head");
    chk("R12 not full", 64'(sq_full), 64'd0);
    chk("R12 tail kept", 64'(sq_tail), 64'd10);
    repeat (2) tick();
    chk("R3 scoreboard drained", 64'(expq.size()), 64'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 64'd1, 64'd0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule